// File: doc/BRIEF.md
# Prescaled Timer/Counter with Auto-Reload and PWM

This block is a single timer/counter made of a low count byte and a high count byte, with a pair of reload bytes beside them. Four counting modes are selected by a two-bit mode input.

- Variable-width mode: the low byte acts as a prescaler of 1 to 8 active bits.
- 16-bit auto-reload mode: reloads from the reload pair.
- 8-bit auto-reload mode: the high byte is the reload value.
- Split mode: only the low byte counts.

Counting steps on every clock or on falling edges of an external pin. A run bit and an optional gate pin control counting. An overflow flag is raised on rollover.

In the two wide modes the block can also drive an asymmetric 8-bit pulse-width output. The high byte is the PWM ramp. The high reload byte serves as the duty compare value. That value is copied into an active compare register only when the ramp wraps, so software may update it at any time without glitching the current period.

Software reaches the count, reload and flag state through a plain write port and a registered read port with one cycle of latency.

Top module: `tmr_pwm_top`

## Requirements
- R1: After reset, the low and high count bytes, both reload bytes and the active compare value are 00h. The overflow flag and the PWM output are 0.
- R2: A count step is taken only when run is 1 and either gate_en is 0 or gate_pin is 1. With run at 0 the count bytes do not change except by bus writes.
- R3: With mode 00 and prescaler select p, the low byte counts in its lowest p+1 bits. When those bits are all ones, a step clears them and increments the high byte. A step from high byte FFh to 00h sets the overflow flag. For example, p=4 gives a 13-bit timer.
- R4: With mode 01 (and PWM off), the 16-bit count increments. A step from FFFFh loads {reload high, reload low} and sets the overflow flag.
- R5: With mode 10, the low byte increments. A step from FFh loads the low byte from the high byte and sets the overflow flag. The high byte never changes in this mode except by a bus write.
- R6: With mode 11, the low byte increments and wraps from FFh to 00h, setting the overflow flag. The high byte holds.
- R7: With cnt_mode at 1, cnt_pin is sampled every clock. A 1 sample followed by a 0 sample yields one step, and the incremented count is in the low byte one clock after the clock that captured the 0.
- R8: The overflow flag is cleared by ovf_ack or by any bus write to address 4. A rollover in the same cycle wins over the clear. Reading address 4 returns the flag in bit 0.
- R9: Changing run from 0 to 1 resumes counting from the held value and does not clear the count.
- R10: With pwm_en at 1 in mode 00 or 01, the high byte steps once per low-byte rollover (in mode 01 the low byte reloads from reload low). pwm_out is 1 while the high byte is below the active compare value and 0 from the compare value to FFh.
- R11: A write to the compare byte (address 3) reaches the active compare value only when the high byte steps from FFh to 00h.
- R12: An active compare value of 00h keeps pwm_out at 0. With pwm_en at 0, or in modes 10 and 11, pwm_out is 0.
- R13: Bus addresses are 0 low count, 1 high count, 2 reload low, 3 reload high/compare, 4 flag. A write to a count byte takes priority over a count step in the same cycle. rd_data presents the addressed register one clock after rd_addr is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counting enable |
| gate_en | input | 1 | Makes counting depend on gate_pin |
| gate_pin | input | 1 | External gate level |
| cnt_mode | input | 1 | 1: step on cnt_pin falling edges, 0: step every clock |
| cnt_pin | input | 1 | External event input |
| mode | input | 2 | Counting mode select |
| psc | input | 3 | Prescaler width select for mode 00 |
| pwm_en | input | 1 | Enables the PWM output |
| ovf_ack | input | 1 | Clears the overflow flag |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 3 | Bus write address |
| wr_data | input | 8 | Bus write data |
| rd_addr | input | 3 | Bus read address |
| rd_data | output | 8 | Registered read data |
| ovf_flag | output | 1 | Overflow flag |
| pwm_out | output | 1 | Registered PWM output |

## Verification
Every count step lands in the count bytes on the same clock edge that sees the enabled step, and a read of those bytes appears on rd_data one edge later. The bench therefore stops counting before it reads, and it samples at falling clock edges after the read edge. For the external pin, a falling input is captured on one edge and the count changes on the next, so the read data, held on the low-byte address, shows it on the edge after that. The bench samples the edge just before and the edge at which the value is due. The flag and pwm_out are registered together with the count, so they are checked at the falling edge after the step that produced them.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    TM_VAR   = 2'b00,
    TM_AR16  = 2'b01,
    TM_AR8   = 2'b10,
    TM_SPLIT = 2'b11
  } tmode_e;

  localparam logic [2:0] A_LO   = 3'd0;
  localparam logic [2:0] A_HI   = 3'd1;
  localparam logic [2:0] A_RLO  = 3'd2;
  localparam logic [2:0] A_RHI  = 3'd3;
  localparam logic [2:0] A_FLAG = 3'd4;
endpackage

// File: rtl/tmr_tick.sv
module tmr_tick (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic gate_en,
  input  logic gate_pin,
  input  logic cnt_mode,
  input  logic cnt_pin,
  output logic tick
);
  logic pin_q1, pin_q2;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q1 <= 1'b0;
      pin_q2 <= 1'b0;
    end else begin
      pin_q1 <= cnt_pin;
      pin_q2 <= pin_q1;
    end
  end

  logic enabled, fall;
  always_comb begin
    enabled = run && (!gate_en || gate_pin);
    fall    = pin_q2 && !pin_q1;
    tick    = enabled && (cnt_mode ? fall : 1'b1);
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int W    = 8,
  parameter int PSCW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  tmode_e          mode,
  input  logic [PSCW-1:0] psc,
  input  logic            pwm_on,
  input  logic [W-1:0]    rlo,
  input  logic [W-1:0]    rhi,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [W-1:0]    wdata,
  output logic [W-1:0]    lo,
  output logic [W-1:0]    hi,
  output logic [W-1:0]    hi_d,
  output logic            ovf,
  output logic            hi_wrap
);
  localparam logic [W-1:0] ONE = 1;

  logic [W:0]   mask_w;
  logic [W-1:0] mask, lo_n, hi_n;
  logic         lo_full, lo_max, hi_max;

  always_comb begin
    mask_w  = ({{W{1'b0}}, 1'b1} << ({1'b0, psc} + 1'b1)) - 1'b1;
    mask    = mask_w[W-1:0];
    lo_full = (lo & mask) == mask;
    lo_max  = &lo;
    hi_max  = &hi;
    lo_n    = lo;
    hi_n    = hi;
    ovf     = 1'b0;
    hi_wrap = 1'b0;
    if (tick) begin
      case (mode)
        TM_VAR: begin
          if (lo_full) begin
            lo_n    = lo & ~mask;
            hi_n    = hi + ONE;
            ovf     = hi_max;
            hi_wrap = hi_max;
          end else begin
            lo_n = lo + ONE;
          end
        end
        TM_AR16: begin
          if (pwm_on) begin
            if (lo_max) begin
              lo_n    = rlo;
              hi_n    = hi + ONE;
              ovf     = hi_max;
              hi_wrap = hi_max;
            end else begin
              lo_n = lo + ONE;
            end
          end else if (lo_max && hi_max) begin
            lo_n = rlo;
            hi_n = rhi;
            ovf  = 1'b1;
          end else begin
            {hi_n, lo_n} = {hi, lo} + {{W{1'b0}}, ONE};
          end
        end
        TM_AR8: begin
          lo_n = lo_max ? hi : lo + ONE;
          ovf  = lo_max;
        end
        default: begin
          lo_n = lo + ONE;
          ovf  = lo_max;
        end
      endcase
    end
    hi_d = wr_hi ? wdata : hi_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= wr_lo ? wdata : lo_n;
      hi <= hi_d;
    end
  end
endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pwm_on,
  input  logic         hi_wrap,
  input  logic [W-1:0] hi_d,
  input  logic [W-1:0] cmp_buf,
  output logic [W-1:0] cmp_act,
  output logic         pwm_q
);
  logic [W-1:0] cmp_n;
  always_comb cmp_n = hi_wrap ? cmp_buf : cmp_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_act <= '0;
      pwm_q   <= 1'b0;
    end else begin
      cmp_act <= cmp_n;
      pwm_q   <= pwm_on && (hi_d < cmp_n);
    end
  end
endmodule

// File: rtl/tmr_pwm_top.sv
module tmr_pwm_top
  import tmr_pkg::*;
#(
  parameter int W    = 8,
  parameter int PSCW = $clog2(W),
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            gate_en,
  input  logic            gate_pin,
  input  logic            cnt_mode,
  input  logic            cnt_pin,
  input  logic [1:0]      mode,
  input  logic [PSCW-1:0] psc,
  input  logic            pwm_en,
  input  logic            ovf_ack,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [W-1:0]    rd_data,
  output logic            ovf_flag,
  output logic            pwm_out
);
  tmode_e       mode_e;
  logic         tick, pwm_on, ovf, hi_wrap;
  logic [W-1:0] lo_q, hi_q, hi_d, rlo_q, rhi_q, cmp_q;

  always_comb begin
    mode_e = tmode_e'(mode);
    pwm_on = pwm_en && !mode[1];
  end

  tmr_tick u_tick (
    .clk(clk), .rst(rst), .run(run), .gate_en(gate_en), .gate_pin(gate_pin),
    .cnt_mode(cnt_mode), .cnt_pin(cnt_pin), .tick(tick)
  );

  tmr_count #(.W(W), .PSCW(PSCW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode_e), .psc(psc),
    .pwm_on(pwm_on), .rlo(rlo_q), .rhi(rhi_q),
    .wr_lo(wr_en && wr_addr == AW'(A_LO)),
    .wr_hi(wr_en && wr_addr == AW'(A_HI)),
    .wdata(wr_data), .lo(lo_q), .hi(hi_q), .hi_d(hi_d),
    .ovf(ovf), .hi_wrap(hi_wrap)
  );

  tmr_pwm #(.W(W)) u_pwm (
    .clk(clk), .rst(rst), .pwm_on(pwm_on), .hi_wrap(hi_wrap), .hi_d(hi_d),
    .cmp_buf(rhi_q), .cmp_act(cmp_q), .pwm_q(pwm_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rlo_q    <= '0;
      rhi_q    <= '0;
      ovf_flag <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (wr_en && wr_addr == AW'(A_RLO)) rlo_q <= wr_data;
      if (wr_en && wr_addr == AW'(A_RHI)) rhi_q <= wr_data;
      if (ovf)
        ovf_flag <= 1'b1;
      else if (ovf_ack || (wr_en && wr_addr == AW'(A_FLAG)))
        ovf_flag <= 1'b0;
      case (rd_addr)
        AW'(A_LO):   rd_data <= lo_q;
        AW'(A_HI):   rd_data <= hi_q;
        AW'(A_RLO):  rd_data <= rlo_q;
        AW'(A_RHI):  rd_data <= rhi_q;
        AW'(A_FLAG): rd_data <= {{(W-1){1'b0}}, ovf_flag};
        default:     rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_pwm_chk.sv
module tmr_pwm_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         run,
  input logic         wr_en,
  input logic [1:0]   mode,
  input logic         pwm_en,
  input logic         ovf_flag,
  input logic         pwm_out,
  input logic [W-1:0] cnt_lo,
  input logic [W-1:0] cnt_hi,
  input logic [W-1:0] cmp_act
);
  // R2: no run and no write means the count is frozen
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_en) |=> $stable({cnt_hi, cnt_lo}));

  // R5: the high byte is the reload source and never steps in mode 10
  a_r5_hi_kept: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && !wr_en) |=> $stable(cnt_hi));

  // R6: the high byte holds in split mode
  a_r6_hi_hold: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11 && !wr_en) |=> $stable(cnt_hi));

  // R8: the flag can only rise from a step taken while running
  a_r8_set_needs_run: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> $past(run));

  // R12: PWM disabled forces the output low
  a_r12_off_low: assert property (@(posedge clk) disable iff (rst)
    !pwm_en |=> !pwm_out);

  // R12: zero compare never produces a high output
  a_r12_zero_low: assert property (@(posedge clk) disable iff (rst)
    pwm_out |-> (cmp_act != '0));
endmodule

bind tmr_pwm_top tmr_pwm_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .wr_en(wr_en), .mode(mode),
  .pwm_en(pwm_en), .ovf_flag(ovf_flag), .pwm_out(pwm_out),
  .cnt_lo(lo_q), .cnt_hi(hi_q), .cmp_act(cmp_q)
);

// File: tb/sim_tmr_pwm_top.sv
`timescale 1ns/1ps
module sim_tmr_pwm_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 0, gate_en = 0, gate_pin = 0, cnt_mode = 0, cnt_pin = 0;
  logic [1:0] mode = 2'b00;
  logic [2:0] psc = 3'd4;
  logic       pwm_en = 0, ovf_ack = 0, wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       ovf_flag, pwm_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  tmr_pwm_top u0 (
    .clk(clk), .rst(rst), .run(run), .gate_en(gate_en), .gate_pin(gate_pin),
    .cnt_mode(cnt_mode), .cnt_pin(cnt_pin), .mode(mode), .psc(psc),
    .pwm_en(pwm_en), .ovf_ack(ovf_ack), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ovf_flag(ovf_flag), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(posedge clk); @(negedge clk); d = rd_data;
  endtask

  task automatic steps(input int n);
    @(negedge clk); run = 1;
    repeat (n) @(posedge clk);
    @(negedge clk); run = 0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk("R1 reg", v, 0);
    end
    chk("R1 flag", ovf_flag, 0);
    chk("R1 pwm", pwm_out, 0);
  endtask

  task automatic t_mode00;
    mode = 2'b00; psc = 3'd4;
    wr(0, 8'h00); wr(1, 8'hFF);
    steps(31);
    rd(0, v); chk("R3 lo before wrap", v, 8'h1F);
    rd(1, v); chk("R3 hi before wrap", v, 8'hFF);
    chk("R3 no flag yet", ovf_flag, 0);
    steps(1);
    rd(1, v); chk("R3 hi wrapped", v, 8'h00);
    chk("R3 flag", ovf_flag, 1);
    psc = 3'd0; wr(4, 0); wr(0, 8'h00); wr(1, 8'h05);
    steps(2);
    rd(1, v); chk("R3 psc0 hi", v, 8'h06);
    rd(0, v); chk("R3 psc0 lo", v, 8'h00);
  endtask

  task automatic t_mode01;
    mode = 2'b01; wr(4, 0);
    wr(2, 8'h34); wr(3, 8'h12); wr(0, 8'hFD); wr(1, 8'hFF);
    steps(2);
    chk("R4 no flag at FFFF", ovf_flag, 0);
    steps(1);
    rd(0, v); chk("R4 reload lo", v, 8'h34);
    rd(1, v); chk("R4 reload hi", v, 8'h12);
    chk("R4 flag", ovf_flag, 1);
    steps(1);
    rd(0, v); chk("R4 count after reload", v, 8'h35);
    rd(4, v); chk("R13 flag read", v, 1);
  endtask

  task automatic t_flag;
    @(negedge clk); ovf_ack = 1; @(negedge clk); ovf_ack = 0;
    chk("R8 ack clears", ovf_flag, 0);
    mode = 2'b11; wr(0, 8'hFF);
    steps(1); chk("R6 flag", ovf_flag, 1);
    wr(4, 8'h00); chk("R8 write clears", ovf_flag, 0);
    wr(0, 8'hFF);
    @(negedge clk); ovf_ack = 1; run = 1;
    @(negedge clk); ovf_ack = 0; run = 0;
    chk("R8 set wins", ovf_flag, 1);
    wr(4, 0);
  endtask

  task automatic t_mode10_11;
    mode = 2'b10; wr(0, 8'hFE); wr(1, 8'h80);
    steps(2);
    rd(0, v); chk("R5 lo reload from hi", v, 8'h80);
    rd(1, v); chk("R5 hi unchanged", v, 8'h80);
    chk("R5 flag", ovf_flag, 1);
    mode = 2'b11; wr(4, 0); wr(0, 8'hFF); wr(1, 8'h55);
    steps(3);
    rd(0, v); chk("R6 lo wraps", v, 8'h02);
    rd(1, v); chk("R6 hi holds", v, 8'h55);
    wr(4, 0);
  endtask

  task automatic t_gate_run;
    mode = 2'b11; wr(0, 8'h00);
    gate_en = 1; gate_pin = 0;
    steps(5);
    rd(0, v); chk("R2 gate low blocks", v, 8'h00);
    gate_pin = 1;
    steps(5);
    rd(0, v); chk("R2 gate high counts", v, 8'h05);
    gate_en = 0; gate_pin = 0;
    repeat (4) @(negedge clk);
    rd(0, v); chk("R2 run low holds", v, 8'h05);
    steps(1);
    rd(0, v); chk("R9 resume without clear", v, 8'h06);
    wr(0, 8'h20);
    @(negedge clk); run = 1; wr_en = 1; wr_addr = 0; wr_data = 8'h40;
    @(negedge clk); run = 0; wr_en = 0;
    rd(0, v); chk("R13 write beats step", v, 8'h40);
  endtask

  task automatic t_counter;
    mode = 2'b11; wr(0, 8'h10);
    cnt_mode = 1; cnt_pin = 1;
    @(negedge clk); rd_addr = 0; run = 1;
    repeat (3) @(negedge clk);
    cnt_pin = 0;
    @(negedge clk); chk("R7 not yet", rd_data, 8'h10);
    @(negedge clk); chk("R7 before read edge", rd_data, 8'h10);
    @(negedge clk); chk("R7 one step", rd_data, 8'h11);
    for (int i = 0; i < 2; i++) begin
      cnt_pin = 1; repeat (2) @(negedge clk);
      cnt_pin = 0; repeat (2) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    run = 0; cnt_mode = 0;
    rd(0, v); chk("R7 three falls", v, 8'h13);
  endtask

  task automatic t_pwm;
    mode = 2'b01; pwm_en = 1;
    wr(2, 8'hFF); wr(0, 8'hFF); wr(3, 8'h04); wr(1, 8'hFF);
    chk("R10 low before wrap", pwm_out, 0);
    steps(1); chk("R10 high at 00", pwm_out, 1);
    steps(1); wr(3, 8'h01);
    steps(2); chk("R11 old compare kept", pwm_out, 1);
    steps(1); chk("R10 low at compare", pwm_out, 0);
    rd(1, v); chk("R10 ramp value", v, 8'h04);
    steps(252); chk("R11 new compare high at 00", pwm_out, 1);
    steps(1); chk("R11 new compare low at 01", pwm_out, 0);
    wr(3, 8'h00);
    steps(255); chk("R12 zero compare low", pwm_out, 0);
    wr(3, 8'h03);
    steps(256); chk("R10 high again", pwm_out, 1);
    @(negedge clk); pwm_en = 0;
    @(negedge clk); chk("R12 disable low", pwm_out, 0);
    wr(4, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_mode00();
    t_mode01();
    t_flag();
    t_mode10_11();
    t_gate_run();
    t_counter();
    t_pwm();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule